// File: doc/BRIEF.md
# System Control Coprocessor Register Bank

This block holds the 64-bit system-control registers that a CPU core reads and writes through its coprocessor move instructions. The core gives a 5-bit register number, write data and a write enable on the write side, and a second register number on the read side. Each write passes through a mask chosen by the register number, so only the fields a register implements are stored. Register numbers that are read-only or not implemented keep their value when written.

The bank also contains a 32-bit free-running counter, a 32-bit compare value and a timer interrupt pending flag. The counter advances once every two clock cycles. When an increment makes it equal to the compare value, the pending flag is set, and it stays set until the compare register is written. The block also produces an interrupt request from the two software interrupt pending bits and their enable bits in the status register.

Top module: `cop_ctl_bank`

## Requirements
- R1: After reset every register reads zero, with two exceptions: number 15 (processor ID) reads parameter PROC_ID and number 16 (configuration) reads parameter CFG_RESET. `irq_o` is 0.
- R2: A write to number 0 (TLB index) or number 6 (wired limit) stores only bits 5:0, and the higher bits read zero. A write to number 4 (context) or number 20 (extended context) stores the data with bits 3:0 forced to zero.
- R3: A write to number 12 (status) stores bits 31:0 with bits 19, 21, 23 and 24 forced to zero. Bits 63:32 read zero.
- R4: A write to number 13 (cause) changes only the software pending bits 9:8. The timer pending bit 15 keeps its value, and every other cause bit reads zero.
- R5: A write to number 16 (configuration) changes only the bits set in CFG_WR_MASK (by default bits 2:0). All other bits keep their value.
- R6: Number 9 (count) is 32 bits wide and advances by one every two clock cycles. A write loads the value in bits 31:0; the register reads the loaded value for two cycles and then keeps counting from it.
- R7: Number 11 (compare) stores bits 31:0. When an increment of count makes it equal to compare, cause bit 15 is set. The bit stays set until compare is written, and that write clears it.
- R8: A write to number 18 (watch low) stores the data with bit 2 forced to zero. Number 19 (watch high) keeps bits 3:0, and number 26 (error code) keeps bits 7:0.
- R9: Numbers 14 (exception PC), 30 (error PC), 17 (link address), 28 (tag low) and 29 (tag high) store all 64 written bits.
- R10: A write to number 15 or to any unimplemented number (for example 7) changes no register. An unimplemented number reads zero.
- R11: `irq_o` is 1 exactly when some bit of cause bits 9:8 and the same bit of status bits 9:8 are both 1.
- R12: The read path is combinational: `rd_data_o` follows `rd_sel_i` in the same cycle, and a write is visible after the clock edge that takes it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to clk |
| wr_en_i | input | 1 | Write strobe |
| wr_sel_i | input | 5 | Register number to write |
| wr_data_i | input | 64 | Write data |
| rd_sel_i | input | 5 | Register number to read |
| rd_data_o | output | 64 | Masked value of the selected register |
| irq_o | output | 1 | Software interrupt request |

## Verification
Each masked register is written with all ones and read back. Against the expected masks this shows whether each bit is stored or dropped, and a second write with a different pattern to some registers separates stuck bits from bits that really are stored. The counter is loaded and then sampled on consecutive cycles, which separates half-rate counting from full-rate counting and from a load that does not take. Compare and count are set so that equality is reached only through an increment, and then through a direct load, which shows whether the pending bit is set only on an increment, held across cause writes and cleared only by a compare write. The interrupt request is checked with pending and enable bits in matching and in non-matching positions.

// File: rtl/cop_pkg.sv
package cop_pkg;
  localparam int unsigned XLEN  = 64;
  localparam int unsigned SEL_W = 5;

  localparam logic [SEL_W-1:0] RNUM_TLB_INDEX  = 5'd0;
  localparam logic [SEL_W-1:0] RNUM_CTX        = 5'd4;
  localparam logic [SEL_W-1:0] RNUM_WIRED_LIM  = 5'd6;
  localparam logic [SEL_W-1:0] RNUM_COUNT      = 5'd9;
  localparam logic [SEL_W-1:0] RNUM_CMP        = 5'd11;
  localparam logic [SEL_W-1:0] RNUM_STATUS     = 5'd12;
  localparam logic [SEL_W-1:0] RNUM_CAUSE      = 5'd13;
  localparam logic [SEL_W-1:0] RNUM_EXC_PC     = 5'd14;
  localparam logic [SEL_W-1:0] RNUM_PROC_ID    = 5'd15;
  localparam logic [SEL_W-1:0] RNUM_CONFIG     = 5'd16;
  localparam logic [SEL_W-1:0] RNUM_LINK_ADDR  = 5'd17;
  localparam logic [SEL_W-1:0] RNUM_WATCH_LO   = 5'd18;
  localparam logic [SEL_W-1:0] RNUM_WATCH_HI   = 5'd19;
  localparam logic [SEL_W-1:0] RNUM_XCTX       = 5'd20;
  localparam logic [SEL_W-1:0] RNUM_ERR_CODE   = 5'd26;
  localparam logic [SEL_W-1:0] RNUM_TAG_LO     = 5'd28;
  localparam logic [SEL_W-1:0] RNUM_TAG_HI     = 5'd29;
  localparam logic [SEL_W-1:0] RNUM_ERR_PC     = 5'd30;

  // cause / status field positions
  localparam int unsigned SW_LSB    = 8;
  localparam int unsigned SW_W      = 2;
  localparam int unsigned TIMER_BIT = 15;

  // registers that are simple masked storage
  localparam int unsigned NPLAIN = 14;

  function automatic logic [SEL_W-1:0] plain_sel(input int unsigned idx);
    case (idx)
      0:       return RNUM_TLB_INDEX;
      1:       return RNUM_WIRED_LIM;
      2:       return RNUM_CTX;
      3:       return RNUM_XCTX;
      4:       return RNUM_STATUS;
      5:       return RNUM_WATCH_LO;
      6:       return RNUM_WATCH_HI;
      7:       return RNUM_ERR_CODE;
      8:       return RNUM_EXC_PC;
      9:       return RNUM_ERR_PC;
      10:      return RNUM_LINK_ADDR;
      11:      return RNUM_TAG_LO;
      12:      return RNUM_TAG_HI;
      default: return RNUM_CAUSE;  // unused slot
    endcase
  endfunction

  function automatic logic [XLEN-1:0] plain_mask(input int unsigned idx);
    case (idx)
      0, 1:    return 64'h0000_0000_0000_003F;
      2, 3:    return ~64'hF;
      4:       return 64'h0000_0000_FE57_FFFF;
      5:       return ~64'h4;
      6:       return 64'h0000_0000_0000_000F;
      7:       return 64'h0000_0000_0000_00FF;
      8, 9, 10, 11, 12: return '1;
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/cop_masked_reg.sv
module cop_masked_reg #(
  parameter int unsigned      W    = 64,
  parameter logic [W-1:0]     MASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_d, q_q;

  always_comb begin
    q_d = q_q;
    if (we_i) q_d = d_i & MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= '0;
    else        q_q <= q_d;
  end

  assign q_o = q_q;

  // R10
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i |=> $stable(q_q));
endmodule

// File: rtl/cop_timer.sv
module cop_timer #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_cnt_i,
  input  logic             ld_cmp_i,
  input  logic [CNT_W-1:0] d_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cmp_o,
  output logic             pend_o
);
  logic             ph_d, ph_q;
  logic [CNT_W-1:0] cnt_d, cnt_q;
  logic [CNT_W-1:0] cmp_d, cmp_q;
  logic             pend_d, pend_q;
  logic             step;
  logic [CNT_W-1:0] cnt_inc;

  assign step    = ph_q && !ld_cnt_i;
  assign cnt_inc = cnt_q + CNT_W'(1);

  always_comb begin
    ph_d   = ld_cnt_i ? 1'b0 : ~ph_q;
    cnt_d  = cnt_q;
    if (ld_cnt_i)  cnt_d = d_i;
    else if (step) cnt_d = cnt_inc;
    cmp_d  = ld_cmp_i ? d_i : cmp_q;
    pend_d = pend_q;
    if (ld_cmp_i)                     pend_d = 1'b0;
    else if (step && cnt_inc == cmp_q) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= 1'b0;
      cnt_q  <= '0;
      cmp_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      cnt_q  <= cnt_d;
      cmp_q  <= cmp_d;
      pend_q <= pend_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign cmp_o  = cmp_q;
  assign pend_o = pend_q;

  // R6
  cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_cnt_i |=> cnt_q == $past(d_i));
  // R6
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ld_cnt_i) |-> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + CNT_W'(1)));
  // R7
  cmp_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_cmp_i |=> !pend_q);
  // R7
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !ld_cmp_i) |=> pend_q);
endmodule

// File: rtl/cop_ctl_bank.sv
module cop_ctl_bank
  import cop_pkg::*;
#(
  parameter int unsigned     CNT_W       = 32,
  parameter logic [XLEN-1:0] PROC_ID     = 64'h0000_0000_0000_0430,
  parameter logic [XLEN-1:0] CFG_RESET   = 64'h0000_0000_0003_04B0,
  parameter logic [XLEN-1:0] CFG_WR_MASK = 64'h0000_0000_0000_0007
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [SEL_W-1:0] wr_sel_i,
  input  logic [XLEN-1:0]  wr_data_i,
  input  logic [SEL_W-1:0] rd_sel_i,
  output logic [XLEN-1:0]  rd_data_o,
  output logic             irq_o
);
  localparam int unsigned SW_MSB = SW_LSB + SW_W - 1;

  logic [XLEN-1:0] plain_q [NPLAIN];

  for (genvar g = 0; g < NPLAIN - 1; g++) begin : g_plain
    localparam logic [SEL_W-1:0] SEL  = plain_sel(g);
    localparam logic [XLEN-1:0]  MASK = plain_mask(g);
    cop_masked_reg #(.W(XLEN), .MASK(MASK)) u_reg (
      .clk  (clk),
      .rst_n(rst_n),
      .we_i (wr_en_i && wr_sel_i == SEL),
      .d_i  (wr_data_i),
      .q_o  (plain_q[g])
    );
  end
  assign plain_q[NPLAIN-1] = '0;

  // timer
  logic [CNT_W-1:0] cnt, cmp;
  logic             tmr_pend;

  cop_timer #(.CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld_cnt_i(wr_en_i && wr_sel_i == RNUM_COUNT),
    .ld_cmp_i(wr_en_i && wr_sel_i == RNUM_CMP),
    .d_i     (wr_data_i[CNT_W-1:0]),
    .cnt_o   (cnt),
    .cmp_o   (cmp),
    .pend_o  (tmr_pend)
  );

  // cause software bits and configuration
  logic            wr_cause, wr_cfg;
  logic [SW_W-1:0] sw_d, sw_q;
  logic [XLEN-1:0] cfg_d, cfg_q;

  assign wr_cause = wr_en_i && wr_sel_i == RNUM_CAUSE;
  assign wr_cfg   = wr_en_i && wr_sel_i == RNUM_CONFIG;

  always_comb begin
    sw_d  = wr_cause ? wr_data_i[SW_MSB:SW_LSB] : sw_q;
    cfg_d = wr_cfg ? ((cfg_q & ~CFG_WR_MASK) | (wr_data_i & CFG_WR_MASK)) : cfg_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_q  <= '0;
      cfg_q <= CFG_RESET;
    end else begin
      sw_q  <= sw_d;
      cfg_q <= cfg_d;
    end
  end

  logic [XLEN-1:0] cause_v, status_v;
  always_comb begin
    cause_v                = '0;
    cause_v[SW_MSB:SW_LSB] = sw_q;
    cause_v[TIMER_BIT]     = tmr_pend;
    status_v               = plain_q[4];
  end

  // read path
  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NPLAIN - 1; i++)
      if (rd_sel_i == plain_sel(i)) rd_data_o = plain_q[i];
    case (rd_sel_i)
      RNUM_COUNT:   rd_data_o = XLEN'(cnt);
      RNUM_CMP:     rd_data_o = XLEN'(cmp);
      RNUM_CAUSE:   rd_data_o = cause_v;
      RNUM_CONFIG:  rd_data_o = cfg_q;
      RNUM_PROC_ID: rd_data_o = PROC_ID;
      default: ;
    endcase
  end

  assign irq_o = |(cause_v[SW_MSB:SW_LSB] & status_v[SW_MSB:SW_LSB]);

  // R5
  cfg_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(cfg_q & ~CFG_WR_MASK));
  // R4
  sw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_cause |=> $stable(sw_q));
  // R11
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_q == '0) |-> !irq_o);
endmodule

// File: tb/test_cop_ctl_bank.sv
module test_cop_ctl_bank;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en_i;
  logic [4:0]  wr_sel_i;
  logic [63:0] wr_data_i;
  logic [4:0]  rd_sel_i;
  logic [63:0] rd_data_o;
  logic        irq_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cop_ctl_bank i_cop_ctl_bank (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
    .wr_data_i(wr_data_i), .rd_sel_i(rd_sel_i), .rd_data_o(rd_data_o), .irq_o(irq_o)
  );

  localparam logic [63:0] ONES = '1;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] sel, input logic [63:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [4:0] sel, input logic [63:0] exp);
    rd_sel_i = sel;
    #1;
    check(req, rd_data_o, exp);
  endtask

  task automatic t_reset;
    rd_chk("R1 index", 5'd0, 64'h0);
    rd_chk("R1 status", 5'd12, 64'h0);
    rd_chk("R1 cause", 5'd13, 64'h0);
    rd_chk("R1 proc id", 5'd15, 64'h430);
    rd_chk("R1 config", 5'd16, 64'h304B0);
    check("R1 irq", {63'b0, irq_o}, 64'h0);
  endtask

  task automatic t_masks;
    wr(5'd0, ONES);  rd_chk("R2 index", 5'd0, 64'h3F);
    wr(5'd6, ONES);  rd_chk("R2 wired", 5'd6, 64'h3F);
    wr(5'd4, ONES);  rd_chk("R2 context", 5'd4, ~64'hF);
    wr(5'd20, 64'h1234_5678_9ABC_DEF7); rd_chk("R2 xcontext", 5'd20, 64'h1234_5678_9ABC_DEF0);
    wr(5'd12, ONES); rd_chk("R3 status", 5'd12, 64'h0000_0000_FE57_FFFF);
    wr(5'd18, ONES); rd_chk("R8 watch lo", 5'd18, ~64'h4);
    wr(5'd19, ONES); rd_chk("R8 watch hi", 5'd19, 64'hF);
    wr(5'd26, ONES); rd_chk("R8 err code", 5'd26, 64'hFF);
    wr(5'd14, 64'hDEAD_BEEF_0123_4567); rd_chk("R9 exc pc", 5'd14, 64'hDEAD_BEEF_0123_4567);
    wr(5'd30, ONES); rd_chk("R9 err pc", 5'd30, ONES);
    wr(5'd17, 64'h8000_0000_0000_0001); rd_chk("R9 link addr", 5'd17, 64'h8000_0000_0000_0001);
    wr(5'd28, 64'hA5A5_5A5A_0F0F_F0F0); rd_chk("R9 tag lo", 5'd28, 64'hA5A5_5A5A_0F0F_F0F0);
    wr(5'd29, 64'h0102_0304_0506_0708); rd_chk("R9 tag hi", 5'd29, 64'h0102_0304_0506_0708);
    rd_chk("R12 comb read index", 5'd0, 64'h3F);
  endtask

  task automatic t_cause_cfg_irq;
    wr(5'd12, 64'h0);
    wr(5'd13, ONES); rd_chk("R4 cause", 5'd13, 64'h300);
    check("R11 irq no enable", {63'b0, irq_o}, 64'h0);
    wr(5'd13, 64'h200); wr(5'd12, 64'h100);
    check("R11 irq mismatch", {63'b0, irq_o}, 64'h0);
    wr(5'd13, 64'h100);
    check("R11 irq match", {63'b0, irq_o}, 64'h1);
    wr(5'd13, 64'h0);
    check("R11 irq cleared", {63'b0, irq_o}, 64'h0);
    wr(5'd16, ONES); rd_chk("R5 config ones", 5'd16, 64'h304B7);
    wr(5'd16, 64'h2); rd_chk("R5 config low", 5'd16, 64'h304B2);
  endtask

  task automatic t_ignored;
    wr(5'd7, ONES);  rd_chk("R10 undefined read", 5'd7, 64'h0);
    rd_chk("R10 index untouched", 5'd0, 64'h3F);
    rd_chk("R10 tag hi untouched", 5'd29, 64'h0102_0304_0506_0708);
    wr(5'd15, ONES); rd_chk("R10 proc id", 5'd15, 64'h430);
  endtask

  task automatic t_count;
    wr(5'd9, 64'hFFFF_FFFF_0000_0064);
    rd_chk("R6 load", 5'd9, 64'h64);
    @(negedge clk); rd_chk("R6 hold", 5'd9, 64'h64);
    @(negedge clk); rd_chk("R6 step1", 5'd9, 64'h65);
    @(negedge clk); rd_chk("R6 hold2", 5'd9, 64'h65);
    @(negedge clk); rd_chk("R6 step2", 5'd9, 64'h66);
  endtask

  task automatic t_timer;
    wr(5'd11, 64'hFFFF_0000_0000_0200);
    rd_chk("R7 compare 32b", 5'd11, 64'h200);
    wr(5'd9, 64'h1FE);
    rd_chk("R7 not yet", 5'd13, 64'h0);
    @(negedge clk); @(negedge clk); @(negedge clk);
    rd_chk("R7 before match", 5'd13, 64'h0);
    @(negedge clk);
    rd_chk("R7 match sets", 5'd13, 64'h8000);
    repeat (6) @(negedge clk);
    rd_chk("R7 stays set", 5'd13, 64'h8000);
    wr(5'd13, 64'h100);
    rd_chk("R4 pending kept", 5'd13, 64'h8100);
    wr(5'd11, 64'h500);
    rd_chk("R7 compare write clears", 5'd13, 64'h100);
    wr(5'd9, 64'h500);
    repeat (4) @(negedge clk);
    rd_chk("R7 load equal no set", 5'd13, 64'h100);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en_i = 1'b0; wr_sel_i = '0; wr_data_i = '0; rd_sel_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_masks();
    t_cause_cfg_irq();
    t_ignored();
    t_count();
    t_timer();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule